// File: doc/BRIEF.md
# MMU Special Register Interface

This unit sits between a processor's special-register access path and the translation entries of a software-managed MMU. It holds an entry index register, a process identifier register, a zone protection register and two general registers. It also exposes a pair of windows onto the selected entry, one for the tag word and one for the data word. A write to the search register runs a translation lookup on the written page address and puts the outcome into the index register. The unit owns the entry storage and the lookup logic, and it drives the storage write port itself.

Two configuration inputs decide which accesses take effect: the MMU mode and the TLB access level. Requests arrive as a one-cycle strobe that carries a 3-bit register number, a read/write select and write data. Read data appears on the clock after the request and holds until the next read.

Register numbers: 0 process ID, 1 zone protection, 2 data window, 3 tag window, 4 index, 5 search, 6 and 7 general. Tag word: bits 31:10 page number, bits 9:7 size code (page size 1 KiB shifted left by twice the code), bit 6 valid. Data word: bits 31:10 physical page, bits 7:4 zone select.

Top module: `mmu_sreg_unit`

## Requirements
- R1: After reset every register reads zero and every entry is invalid, so a search misses.
- R2: The index register and the general registers 6 and 7 store any written value and return it on a read. Read data is valid on the clock after the request.
- R3: Bits 7:0 of the index register select the entry. Bit 0 of the window register number selects the tag word (1) or the data word (0). A tag-window write also stores bits 7:0 of the process ID as the entry's translation ID.
- R4: A permitted tag-window read loads the process ID register with the entry's stored translation ID.
- R5: On a search hit the index register takes the matching entry number, and the lowest-numbered match wins. An entry matches when it is valid, its page matches at its own size, and its translation ID is zero or equals bits 7:0 of the process ID.
- R6: On a search miss, bit 31 of the index register is set and bits 30:0 keep their value.
- R7: In user mode, an entry whose zone field in the zone register (bits 31-2z:30-2z for zone z) reads 0 is skipped. A zone select above parameter NUM_ZONES counts as accessible.
- R8: With mode below 2 or access level 0, every read returns zero and every write has no effect.
- R9: Writes to the process ID, zone and search registers have no effect unless the access level is above 1.
- R10: Reads of the two windows, the process ID and the zone register return zero unless bit 0 of the access level is set. Such a blocked tag-window read leaves the process ID unchanged.
- R11: An index at or above ENTRIES makes window reads return zero. Window writes with such an index have no effect, and reads through it leave the process ID unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | MMU mode; below 2 disables the unit |
| cfg_access | input | 2 | TLB access level |
| user_mode | input | 1 | Current privilege is user |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_reg | input | 3 | Register number |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, one clock after the request |

## Verification
The bench builds the unit with ENTRIES=4 and NUM_ZONES=8. With only four entries, an index of 5 is out of range, so the R11 window guards can be reached. With zones capped at 8, an entry that selects zone 10 shows the override to accessible, even though its zone field in the zone register reads 0. Priority is covered with a global 16 KiB entry and a 1 KiB entry that overlap.

// File: rtl/mmu_sreg_pkg.sv
// Shared register numbers, word field positions and helpers for the MMU
// special register unit. Assumes 32-bit words and 1 KiB minimum pages.
package mmu_sreg_pkg;

    typedef enum logic [2:0] {
        SR_PID    = 3'd0,
        SR_ZONE   = 3'd1,
        SR_TLB_LO = 3'd2,
        SR_TLB_HI = 3'd3,
        SR_INDEX  = 3'd4,
        SR_SEARCH = 3'd5,
        SR_AUX0   = 3'd6,
        SR_AUX1   = 3'd7
    } sreg_e;

    localparam int          WORD_W    = 32;
    localparam int          TID_W     = 8;
    localparam int          VALID_BIT = 6;
    localparam int          SIZE_LSB  = 7;
    localparam int          ZONE_LSB  = 4;
    localparam logic [31:0] EPN_MASK  = 32'hFFFF_FC00;

    // Mask that keeps the address bits above the page offset for a size code.
    function automatic logic [31:0] page_mask(input logic [2:0] code);
        logic [4:0] lsb;
        lsb = 5'd10 + {1'b0, code, 1'b0};
        return ~((32'd1 << lsb) - 32'd1);
    endfunction

endpackage

// File: rtl/mmu_tlb_store.sv
// Translation entry storage: tag, data and translation ID per entry, one
// write port and one read port. Assumes at most one word written per cycle.
module mmu_tlb_store
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_tag_en,
    input  logic                           wr_data_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WORD_W-1:0]              wr_word,
    input  logic [TID_W-1:0]               wr_tid,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [WORD_W-1:0]              rd_tag,
    output logic [WORD_W-1:0]              rd_data,
    output logic [TID_W-1:0]               rd_tid,
    output logic [ENTRIES-1:0][WORD_W-1:0] tag_vec,
    output logic [ENTRIES-1:0][WORD_W-1:0] data_vec,
    output logic [ENTRIES-1:0][TID_W-1:0]  tid_vec
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Entry e: clear on reset, take the addressed word on a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_vec[e]  <= '0;
                data_vec[e] <= '0;
                tid_vec[e]  <= '0;
            end else begin
                if (wr_tag_en && wr_idx == IDX_W'(e)) begin
                    tag_vec[e] <= wr_word;
                    tid_vec[e] <= wr_tid;
                end
                if (wr_data_en && wr_idx == IDX_W'(e)) begin
                    data_vec[e] <= wr_word;
                end
            end
        end
    end

    // Read port: combinational selection of one entry.
    always_comb begin
        rd_tag  = tag_vec[rd_idx];
        rd_data = data_vec[rd_idx];
        rd_tid  = tid_vec[rd_idx];
    end

    AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tag_en |=> tag_vec[$past(wr_idx)] == $past(wr_word)
                      && tid_vec[$past(wr_idx)] == $past(wr_tid)); // R3

endmodule

// File: rtl/mmu_tlb_search.sv
// Combinational lookup across all entries for a read access at the given
// privilege. Returns the lowest matching entry. Assumes ZPR zone z sits in
// bits 31-2z:30-2z and that a zone value of 0 denies user access.
module mmu_tlb_search
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int NUM_ZONES = 15,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][WORD_W-1:0] tag_vec,
    input  logic [ENTRIES-1:0][WORD_W-1:0] data_vec,
    input  logic [ENTRIES-1:0][TID_W-1:0]  tid_vec,
    input  logic [WORD_W-1:0]              va,
    input  logic [TID_W-1:0]               pid,
    input  logic [WORD_W-1:0]              zpr,
    input  logic                           user_mode,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);

    localparam logic [4:0] ZONE_LIM = 5'(NUM_ZONES);

    logic [ENTRIES-1:0] match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        logic [31:0] mask;
        logic [3:0]  zsel;
        logic [4:0]  zsh;
        logic [31:0] zshift;
        logic [1:0]  zval;
        logic        addr_ok, tid_ok, zone_ok;

        // Per-entry match: valid, page, translation ID and zone access.
        always_comb begin
            mask    = page_mask(tag_vec[e][SIZE_LSB +: 3]);
            addr_ok = ((va ^ tag_vec[e]) & mask) == 32'd0;
            tid_ok  = (tid_vec[e] == '0) || (tid_vec[e] == pid);
            zsel    = data_vec[e][ZONE_LSB +: 4];
            zsh     = 5'd30 - {zsel, 1'b0};
            zshift  = zpr >> zsh;
            zval    = zshift[1:0];
            if ({1'b0, zsel} > ZONE_LIM) zval = 2'd1;
            zone_ok = !(user_mode && zval == 2'd0);
            match[e] = tag_vec[e][VALID_BIT] && addr_ok && tid_ok && zone_ok;
        end
    end

    // Priority pick: the lowest-numbered matching entry wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mmu_sreg_unit.sv
// MMU special register unit: decodes register reads and writes, gates them by
// MMU mode and access level, drives the entry store and runs searches.
// Assumes single-cycle request strobes; read data is registered.
module mmu_sreg_unit
    import mmu_sreg_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int NUM_ZONES = 15,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_mode,
    input  logic [1:0]  cfg_access,
    input  logic        user_mode,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [2:0]  req_reg,
    input  logic [31:0] req_wdata,
    output logic [31:0] rsp_rdata
);

    localparam logic [8:0] ENT_LIM = 9'(ENTRIES);

    logic [31:0] pid_q, zone_q, index_q, aux0_q, aux1_q;
    logic        unit_on, priv_wr, rd_ok, in_range, is_window;
    logic        wr_go, rd_go, hi_read_load;
    logic [IDX_W-1:0] ent;
    logic [31:0] rd_tag, rd_data, rd_val;
    logic [TID_W-1:0] rd_tid;
    logic [ENTRIES-1:0][WORD_W-1:0] tag_vec, data_vec;
    logic [ENTRIES-1:0][TID_W-1:0]  tid_vec;
    logic        srch_hit;
    logic [IDX_W-1:0] srch_idx;

    // Access gating and entry selection.
    always_comb begin
        unit_on   = (cfg_mode >= 2'd2) && (cfg_access != 2'd0);
        priv_wr   = cfg_access > 2'd1;
        rd_ok     = cfg_access[0];
        in_range  = {1'b0, index_q[7:0]} < ENT_LIM;
        ent       = index_q[IDX_W-1:0];
        is_window = req_reg[2:1] == 2'b01;
        wr_go     = req_valid && req_write && unit_on;
        rd_go     = req_valid && !req_write && unit_on;
        hi_read_load = rd_go && rd_ok && in_range && req_reg == SR_TLB_HI;
    end

    mmu_tlb_store #(.ENTRIES(ENTRIES)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_tag_en  (wr_go && is_window && in_range && req_reg[0]),
        .wr_data_en (wr_go && is_window && in_range && !req_reg[0]),
        .wr_idx     (ent),
        .wr_word    (req_wdata),
        .wr_tid     (pid_q[TID_W-1:0]),
        .rd_idx     (ent),
        .rd_tag     (rd_tag),
        .rd_data    (rd_data),
        .rd_tid     (rd_tid),
        .tag_vec    (tag_vec),
        .data_vec   (data_vec),
        .tid_vec    (tid_vec)
    );

    mmu_tlb_search #(.ENTRIES(ENTRIES), .NUM_ZONES(NUM_ZONES)) search_i (
        .tag_vec   (tag_vec),
        .data_vec  (data_vec),
        .tid_vec   (tid_vec),
        .va        (req_wdata & EPN_MASK),
        .pid       (pid_q[TID_W-1:0]),
        .zpr       (zone_q),
        .user_mode (user_mode),
        .hit       (srch_hit),
        .hit_idx   (srch_idx)
    );

    // Read multiplexer with per-register gating.
    always_comb begin
        rd_val = '0;
        unique case (sreg_e'(req_reg))
            SR_PID:    rd_val = rd_ok ? pid_q : '0;
            SR_ZONE:   rd_val = rd_ok ? zone_q : '0;
            SR_TLB_LO: rd_val = (rd_ok && in_range) ? rd_data : '0;
            SR_TLB_HI: rd_val = (rd_ok && in_range) ? rd_tag : '0;
            SR_INDEX:  rd_val = index_q;
            SR_SEARCH: rd_val = '0;
            SR_AUX0:   rd_val = aux0_q;
            SR_AUX1:   rd_val = aux1_q;
            default:   rd_val = '0;
        endcase
    end

    // Registered read data; zero for a disabled read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (req_valid && !req_write) rsp_rdata <= unit_on ? rd_val : '0;
    end

    // Process ID: privileged write, or load from a tag-window read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pid_q <= '0;
        else if (wr_go && priv_wr && req_reg == SR_PID) pid_q <= req_wdata;
        else if (hi_read_load)                         pid_q <= {24'd0, rd_tid};
    end

    // Zone protection register: privileged write only.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     zone_q <= '0;
        else if (wr_go && priv_wr && req_reg == SR_ZONE) zone_q <= req_wdata;
    end

    // Index register: direct write, or search result.
    always_ff @(posedge clk) begin
        if (!rst_n) index_q <= '0;
        else if (wr_go && req_reg == SR_INDEX) index_q <= req_wdata;
        else if (wr_go && priv_wr && req_reg == SR_SEARCH) begin
            if (srch_hit) index_q <= 32'(srch_idx);
            else          index_q <= index_q | 32'h8000_0000;
        end
    end

    // General registers: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux0_q <= '0;
            aux1_q <= '0;
        end else if (wr_go && req_reg == SR_AUX0) aux0_q <= req_wdata;
        else if (wr_go && req_reg == SR_AUX1)     aux1_q <= req_wdata;
    end

    AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !unit_on) |=> rsp_rdata == 32'd0); // R8
    AST_OFF_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !unit_on) |=>
        $stable(pid_q) && $stable(zone_q) && $stable(index_q)); // R8
    AST_GUARDED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && cfg_access < 2'd2 &&
         (req_reg == SR_PID || req_reg == SR_ZONE || req_reg == SR_SEARCH)) |=>
        $stable(pid_q) && $stable(zone_q) && $stable(index_q)); // R9
    AST_MISS_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && priv_wr && req_reg == SR_SEARCH && !srch_hit) |=>
        index_q[31] && index_q[30:0] == $past(index_q[30:0])); // R6
    AST_HI_READ_PID: assert property (@(posedge clk) disable iff (!rst_n)
        hi_read_load |=> pid_q == {24'd0, $past(rd_tid)}); // R4
    AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !cfg_access[0] && req_reg != SR_INDEX &&
         req_reg[2:1] != 2'b11 && req_reg != SR_SEARCH) |=> rsp_rdata == 32'd0); // R10

endmodule

// File: tb/mmu_sreg_unit_tb_top.sv
module mmu_sreg_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_mode = 2'd2;
    logic [1:0]  cfg_access = 2'd3;
    logic        user_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_reg = 3'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    mmu_sreg_unit #(.ENTRIES(4), .NUM_ZONES(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_access(cfg_access),
        .user_mode(user_mode), .req_valid(req_valid), .req_write(req_write),
        .req_reg(req_reg), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata)
    );

    // Vector: {write, register, data}; for reads data is the expected value.
    localparam logic [35:0] VEC [15] = '{
        {1'b1, 3'd4, 32'h0000_0002},
        {1'b0, 3'd4, 32'h0000_0002},
        {1'b1, 3'd0, 32'h0000_01A5},
        {1'b0, 3'd0, 32'h0000_01A5},
        {1'b1, 3'd2, 32'h1234_5F30},
        {1'b1, 3'd3, 32'h4000_0040},
        {1'b0, 3'd2, 32'h1234_5F30},
        {1'b0, 3'd3, 32'h4000_0040},
        {1'b0, 3'd0, 32'h0000_00A5},
        {1'b1, 3'd6, 32'hDEAD_BEEF},
        {1'b0, 3'd6, 32'hDEAD_BEEF},
        {1'b1, 3'd5, 32'h4000_03FF},
        {1'b0, 3'd4, 32'h0000_0002},
        {1'b1, 3'd5, 32'h5000_0000},
        {1'b0, 3'd4, 32'h8000_0002}
    };

    task automatic op(input logic wr, input logic [2:0] r, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_reg = r; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] r, input logic [31:0] exp, input string tag);
        op(1'b0, r, 32'd0);
        n_chk++;
        if (rsp_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: reg %0d got %h expected %h", tag, r, rsp_rdata, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_rd(3'd4, 32'd0, "R1 index");
        chk_rd(3'd0, 32'd0, "R1 pid");
        chk_rd(3'd1, 32'd0, "R1 zone");
        chk_rd(3'd7, 32'd0, "R1 aux");
        op(1'b1, 3'd5, 32'd0);
        chk_rd(3'd4, 32'h8000_0000, "R1 search misses");

        // Vector walk (R2 R3 R4 R5 R6)
        for (int i = 0; i < 15; i++) begin
            if (VEC[i][35]) op(1'b1, VEC[i][34:32], VEC[i][31:0]);
            else chk_rd(VEC[i][34:32], VEC[i][31:0], "R2 R3 R4 R5 R6 vector");
        end

        // R5 size, priority, translation ID
        op(1'b1, 3'd0, 32'd0);
        op(1'b1, 3'd4, 32'd1);
        op(1'b1, 3'd3, 32'h4000_0140);
        op(1'b1, 3'd5, 32'h4000_3C00);
        chk_rd(3'd4, 32'd1, "R5 16K page");
        op(1'b1, 3'd0, 32'hA5);
        op(1'b1, 3'd5, 32'h4000_0000);
        chk_rd(3'd4, 32'd1, "R5 lowest wins");
        op(1'b1, 3'd0, 32'h11);
        op(1'b1, 3'd3, 32'd0);
        op(1'b1, 3'd5, 32'h4000_0000);
        chk_rd(3'd4, 32'h8000_0001, "R5 tid mismatch misses");

        // R7 zones
        op(1'b1, 3'd0, 32'hA5);
        user_mode = 1'b1;
        op(1'b1, 3'd5, 32'h4000_0000);
        chk_rd(3'd4, 32'h8000_0001, "R7 zone 0 denies user");
        op(1'b1, 3'd1, 32'h0100_0000);
        op(1'b1, 3'd5, 32'h4000_0000);
        chk_rd(3'd4, 32'd2, "R7 zone opened");
        op(1'b1, 3'd4, 32'd3);
        op(1'b1, 3'd2, 32'h0000_00A0);
        op(1'b1, 3'd3, 32'h6000_0040);
        op(1'b1, 3'd5, 32'h6000_0000);
        chk_rd(3'd4, 32'd3, "R7 zone above limit");
        user_mode = 1'b0;

        // R11 out-of-range index
        op(1'b1, 3'd4, 32'd5);
        op(1'b1, 3'd2, 32'h5555);
        chk_rd(3'd2, 32'd0, "R11 lo read");
        chk_rd(3'd3, 32'd0, "R11 hi read");
        chk_rd(3'd0, 32'hA5, "R11 pid untouched");
        op(1'b1, 3'd4, 32'd3);
        chk_rd(3'd2, 32'h0000_00A0, "R11 entry 3 data kept");
        op(1'b1, 3'd4, 32'd5);

        // R8 unit disabled
        cfg_access = 2'd0;
        op(1'b1, 3'd6, 32'd1);
        chk_rd(3'd6, 32'd0, "R8 read zero");
        cfg_access = 2'd3;
        chk_rd(3'd6, 32'hDEAD_BEEF, "R8 write ignored");
        cfg_mode = 2'd1;
        chk_rd(3'd4, 32'd0, "R8 mode 1 read");
        op(1'b1, 3'd4, 32'd7);
        cfg_mode = 2'd2;
        chk_rd(3'd4, 32'd5, "R8 mode 1 write");

        // R9 privileged writes
        cfg_access = 2'd1;
        op(1'b1, 3'd0, 32'h33);
        op(1'b1, 3'd1, 32'd0);
        op(1'b1, 3'd5, 32'h6000_0000);
        chk_rd(3'd0, 32'hA5, "R9 pid");
        chk_rd(3'd1, 32'h0100_0000, "R9 zone");
        chk_rd(3'd4, 32'd5, "R9 search");

        // R10 read gating
        cfg_access = 2'd2;
        op(1'b1, 3'd4, 32'd2);
        op(1'b1, 3'd0, 32'h77);
        chk_rd(3'd0, 32'd0, "R10 pid");
        chk_rd(3'd1, 32'd0, "R10 zone");
        chk_rd(3'd3, 32'd0, "R10 hi");
        chk_rd(3'd4, 32'd2, "R10 index ungated");
        cfg_access = 2'd3;
        chk_rd(3'd0, 32'h77, "R10 pid not loaded");
        chk_rd(3'd3, 32'h4000_0040, "R4 hi read");
        chk_rd(3'd0, 32'hA5, "R4 pid loaded");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule